// File: doc/BRIEF.md
# Selectable GPIO Interrupt Channel Bank

This block turns a wide vector of general-purpose input lines into a bank of 32 interrupt requests. Every channel has its own source selector, so any of the 128 input lines can be routed to any channel, and two channels may watch the same line. Each channel detects one programmable condition on its line: rising edge, falling edge, high level or low level. When the condition is seen it latches a status bit, and it drives an active-high level request while that bit is set and the channel is enabled.

Software controls the bank through a flat 32-bit register bus. Writes are word-wide and take effect at the clock edge on which `bus_we_i` is high. Reads are combinational from `bus_addr_i`. Channel configuration lives in two kinds of register. The first is a selector word that packs four channels, each as one byte holding an enable bit and a source index. The second is a sense word that packs sixteen channels, each as a 2-bit code. A shared status word collects the latched events, and software clears them one bit at a time by writing zero to a bit. The bank takes care that reprogramming a channel never produces an event of its own.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads 0 (status 0x20, sense 0x24 and 0x28, selectors 0x30 to 0x4C) and `irq_o` is 0.
- R2: Channel c's selector byte sits in the word at 0x30 + 4·(c/4), at bits [8·(c mod 4)+7 : 8·(c mod 4)]. Bit 7 of the byte is the enable and bits 6:0 are the source index into `gpio_i`. Channel c's sense code sits in the word at 0x24 for c < 16 and at 0x28 otherwise, at bits [2·(c mod 16)+1 : 2·(c mod 16)]. All of these read back as written.
- R3: With sense code 0 (rising), an enabled channel's status bit (bit c of 0x20) reads 1 in the cycle after the selected line goes from 0 to 1.
- R4: With sense code 1 (falling), an enabled channel's status bit sets in the cycle after the selected line goes from 1 to 0.
- R5: With sense code 2 an enabled channel sets status while its line is 1. With code 3 it sets status while its line is 0. After a sense change the level is acted on from the second cycle after the write.
- R6: Writing 0x20 clears every status bit written as 0 and leaves every bit written as 1 unchanged. If the detected condition is present in the same cycle, the set wins.
- R7: `irq_o[c]` is status bit c ANDed with the enable bit of channel c. Clearing the enable drops the request but keeps the status bit.
- R8: A disabled channel never sets its status bit. This holds for edges, levels and reprogramming of its source or sense.
- R9: Changing an enabled channel's source index or sense code does not by itself report an edge. The transition of the selected line caused by the switch is ignored.
- R10: Several channels may select the same input line, and each of them detects independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gpio_i | input | 128 | Input lines, synchronous to clk_i |
| bus_we_i | input | 1 | Word write strobe |
| bus_addr_i | input | 8 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, 0 for unmapped addresses |
| irq_o | output | 32 | Level-high request per channel |

## Verification
The hardest case to reach from the ports is a source switch on an enabled channel where the old and new lines differ. In that case the detector would see a false edge for exactly one cycle. The bench parks a 0 on the old line and a 1 on the new line, rewrites the selector while the channel is armed for rising edges, and confirms that the status stays clear. It then produces a real edge on the new line to show the channel is still live. Disabled channels get the same treatment: the bench reprograms them, toggles their lines and then enables them over a line that is already high.

// File: rtl/gib_pkg.sv
package gib_pkg;
  localparam int DATA_W   = 32;
  localparam int BYTE_W   = 8;
  localparam int SENSE_W  = 2;
  localparam int STAT_OFS = 'h20;
  localparam int SNS_OFS  = 'h24;
  localparam int SEL_OFS  = 'h30;

  typedef enum logic [SENSE_W-1:0] {
    SENSE_RISE = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_HIGH = 2'd2,
    SENSE_LOW  = 2'd3
  } sense_e;
endpackage

// File: rtl/gib_regs.sv
module gib_regs
  import gib_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int SRC_W  = 7,
  parameter int ADDR_W = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [DATA_W-1:0]            rdata_o,
  input  logic [NUM_CH-1:0]            status_i,
  output logic [NUM_CH-1:0]            en_o,
  output logic [NUM_CH-1:0][SRC_W-1:0] src_o,
  output sense_e [NUM_CH-1:0]          sense_o,
  output logic [NUM_CH-1:0]            chg_o,
  output logic [NUM_CH-1:0]            clr_o
);
  localparam int CH_PER_SEL = DATA_W / BYTE_W;
  localparam int CH_PER_SNS = DATA_W / SENSE_W;
  localparam int NSEL       = NUM_CH / CH_PER_SEL;
  localparam int NSNS       = NUM_CH / CH_PER_SNS;
  localparam int EN_BIT     = BYTE_W - 1;

  logic [NSEL-1:0][DATA_W-1:0] sel_q;
  logic [NSNS-1:0][DATA_W-1:0] sns_q;
  logic [NSEL-1:0]             sel_hit;
  logic [NSNS-1:0]             sns_hit;
  logic                        stat_hit;

  assign stat_hit = we_i && (int'(addr_i) == STAT_OFS);

  for (genvar k = 0; k < NSEL; k++) begin : g_sel
    assign sel_hit[k] = we_i && (int'(addr_i) == SEL_OFS + 4 * k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         sel_q[k] <= '0;
      else if (sel_hit[k]) sel_q[k] <= wdata_i;
    end
    // selector words change only on their own write strobe
    assert_sel_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sel_hit[k] |=> $stable(sel_q[k]));
  end

  for (genvar k = 0; k < NSNS; k++) begin : g_sns
    assign sns_hit[k] = we_i && (int'(addr_i) == SNS_OFS + 4 * k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         sns_q[k] <= '0;
      else if (sns_hit[k]) sns_q[k] <= wdata_i;
    end
    assert_sns_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sns_hit[k] |=> $stable(sns_q[k]));
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int SW  = c / CH_PER_SEL;
    localparam int SB  = (c % CH_PER_SEL) * BYTE_W;
    localparam int NW  = c / CH_PER_SNS;
    localparam int NB  = (c % CH_PER_SNS) * SENSE_W;
    logic [BYTE_W-1:0]  cur_byte, new_byte;
    logic [SENSE_W-1:0] new_sns;

    assign cur_byte   = sel_q[SW][SB +: BYTE_W];
    assign new_byte   = wdata_i[SB +: BYTE_W];
    assign new_sns    = wdata_i[NB +: SENSE_W];
    assign en_o[c]    = cur_byte[EN_BIT];
    assign src_o[c]   = cur_byte[SRC_W-1:0];
    assign sense_o[c] = sense_e'(sns_q[NW][NB +: SENSE_W]);
    // any change of what the detector looks at
    assign chg_o[c]   = (sel_hit[SW] && (new_byte[SRC_W-1:0] != cur_byte[SRC_W-1:0]))
                     || (sns_hit[NW] && (new_sns != sns_q[NW][NB +: SENSE_W]));
    assign clr_o[c]   = stat_hit && !wdata_i[c];
  end

  always_comb begin
    rdata_o = '0;
    if (int'(addr_i) == STAT_OFS) rdata_o = DATA_W'(status_i);
    for (int k = 0; k < NSEL; k++)
      if (int'(addr_i) == SEL_OFS + 4 * k) rdata_o = sel_q[k];
    for (int k = 0; k < NSNS; k++)
      if (int'(addr_i) == SNS_OFS + 4 * k) rdata_o = sns_q[k];
  end
endmodule

// File: rtl/gib_channel.sv
module gib_channel
  import gib_pkg::*;
#(
  parameter int GPIO_W = 128,
  parameter int SRC_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [GPIO_W-1:0] gpio_i,
  input  logic              en_i,
  input  logic [SRC_W-1:0]  src_i,
  input  sense_e            sense_i,
  input  logic              chg_i,
  input  logic              clr_i,
  output logic              status_o,
  output logic              irq_o
);
  logic line, prev_q, skip_q, status_q, hit, set;

  if (GPIO_W >= (1 << SRC_W)) begin : g_full
    assign line = gpio_i[src_i];
  end else begin : g_guard
    // index past the vector reads as 0
    assign line = (int'(src_i) < GPIO_W) ? gpio_i[src_i] : 1'b0;
  end

  always_comb begin
    unique case (sense_i)
      SENSE_RISE: hit = line & ~prev_q;
      SENSE_FALL: hit = ~line & prev_q;
      SENSE_HIGH: hit = line;
      SENSE_LOW:  hit = ~line;
      default:    hit = 1'b0;
    endcase
  end

  // first cycle on a new source/sense compares against a stale sample
  assign set = en_i & ~skip_q & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= 1'b0;
      skip_q   <= 1'b0;
      status_q <= 1'b0;
    end else begin
      prev_q   <= line;
      skip_q   <= chg_i;
      status_q <= set | (status_q & ~clr_i);
    end
  end

  assign status_o = status_q;
  assign irq_o    = status_q & en_i;

  assert_no_set_disabled_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !status_q) |=> !status_q);
  assert_switch_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (skip_q && !status_q) |=> !status_q);
  assert_clear_only_by_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q && !clr_i) |=> status_q);
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gib_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int GPIO_W = 128,
  parameter int SRC_W  = 7,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [GPIO_W-1:0] gpio_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0]            en, chg, clr, status;
  logic [NUM_CH-1:0][SRC_W-1:0] src;
  sense_e [NUM_CH-1:0]          sense;

  gib_regs #(.NUM_CH(NUM_CH), .SRC_W(SRC_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (bus_we_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .rdata_o  (bus_rdata_o),
    .status_i (status),
    .en_o     (en),
    .src_o    (src),
    .sense_o  (sense),
    .chg_o    (chg),
    .clr_o    (clr)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    gib_channel #(.GPIO_W(GPIO_W), .SRC_W(SRC_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .gpio_i   (gpio_i),
      .en_i     (en[c]),
      .src_i    (src[c]),
      .sense_i  (sense[c]),
      .chg_i    (chg[c]),
      .clr_i    (clr[c]),
      .status_o (status[c]),
      .irq_o    (irq_o[c])
    );
  end
endmodule

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] gpio = '0;
  logic         we = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [31:0]  irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] sel_sh [8];
  logic [31:0] sns_sh [2];

  always #2 clk = ~clk;

  gpio_irq_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .gpio_i(gpio), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ch(input int c, input bit en, input int src);
    sel_sh[c/4][8*(c%4) +: 8] = {en, 7'(src)};
    wr(8'(8'h30 + 4*(c/4)), sel_sh[c/4]);
    cyc(1);
  endtask

  task automatic set_sense(input int c, input int code);
    sns_sh[c/16][2*(c%16) +: 2] = 2'(code);
    wr(8'(8'h24 + 4*(c/16)), sns_sh[c/16]);
    cyc(1);
  endtask

  task automatic set_gpio(input int i, input bit v);
    gpio[i] = v;
    cyc(1);
  endtask

  task automatic chk_stat(input string tag, input logic [31:0] exp);
    logic [31:0] d;
    rd(8'h20, d);
    check(tag, d, exp);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h20, d); check("R1 status", d, 0);
    rd(8'h24, d); check("R1 sense lo", d, 0);
    rd(8'h28, d); check("R1 sense hi", d, 0);
    for (int k = 0; k < 8; k++) begin
      rd(8'(8'h30 + 4*k), d);
      check("R1 select", d, 0);
    end
    check("R1 irq", irq, 0);
  endtask

  task automatic t_regmap;
    logic [31:0] d;
    set_ch(7, 1, 10);
    rd(8'h34, d); check("R2 select ch7 byte3", d, 32'h8A00_0000);
    set_sense(19, 2);
    rd(8'h28, d); check("R2 sense ch19", d, 32'h0000_0080);
    set_ch(7, 0, 0);
    set_sense(19, 0);
    chk_stat("R2 no side status", 0);
  endtask

  task automatic t_rising;
    set_ch(5, 1, 20);
    chk_stat("R3 idle", 0);
    set_gpio(20, 1);
    chk_stat("R3 rise status", 32'h20);
    check("R7 rise irq", irq, 32'h20);
    wr(8'h20, 32'hFFFF_FFFF);
    chk_stat("R6 write ones keeps", 32'h20);
    wr(8'h20, ~32'h20);
    chk_stat("R6 write zero clears", 0);
    check("R7 irq after clear", irq, 0);
  endtask

  task automatic t_falling;
    set_sense(5, 1);
    chk_stat("R4 no fall yet", 0);
    set_gpio(20, 0);
    chk_stat("R4 fall status", 32'h20);
    wr(8'h20, 0);
    chk_stat("R4 cleared", 0);
  endtask

  task automatic t_level;
    set_sense(5, 2);
    chk_stat("R5 high mode line low", 0);
    set_gpio(20, 1);
    chk_stat("R5 high level sets", 32'h20);
    wr(8'h20, 0);
    chk_stat("R6 level persists", 32'h20);
    set_gpio(20, 0);
    wr(8'h20, 0);
    chk_stat("R5 cleared when low", 0);
    set_sense(5, 3);
    chk_stat("R5 low mode skip cycle", 0);
    cyc(1);
    chk_stat("R5 low level sets", 32'h20);
    set_gpio(20, 1);
    wr(8'h20, 0);
    chk_stat("R5 low mode line high", 0);
    set_sense(5, 0);
    set_ch(5, 0, 0);
    gpio[20] = 1'b0;
    cyc(2);
    wr(8'h20, 0);
  endtask

  task automatic t_disabled;
    set_ch(9, 0, 30);
    set_gpio(30, 1);
    set_gpio(30, 0);
    chk_stat("R8 disabled edges", 0);
    gpio[31] = 1'b1;
    set_ch(9, 0, 31);
    cyc(1);
    chk_stat("R8 disabled reprogram", 0);
    check("R8 disabled irq", irq, 0);
    set_sense(9, 2);
    cyc(2);
    chk_stat("R8 disabled level", 0);
    set_sense(9, 0);
    set_ch(9, 1, 31);
    cyc(2);
    chk_stat("R8 enable over high line", 0);
    check("R8 enable irq", irq, 0);
    set_gpio(31, 0);
    set_gpio(31, 1);
    chk_stat("R8 live after enable", 32'h200);
    set_ch(9, 0, 0);
    gpio[31] = 1'b0;
    cyc(2);
    wr(8'h20, 0);
  endtask

  task automatic t_switch;
    set_ch(12, 1, 40);
    gpio[41] = 1'b1;
    cyc(2);
    set_ch(12, 1, 41);
    cyc(2);
    chk_stat("R9 source switch quiet", 0);
    check("R9 switch irq", irq, 0);
    set_gpio(41, 0);
    set_gpio(41, 1);
    chk_stat("R9 new source live", 32'h1000);
    set_ch(12, 0, 0);
    gpio[41] = 1'b0;
    cyc(2);
    wr(8'h20, 0);
  endtask

  task automatic t_shared;
    set_ch(0, 1, 127);
    set_ch(31, 1, 127);
    set_gpio(127, 1);
    chk_stat("R10 shared line status", 32'h8000_0001);
    check("R10 shared line irq", irq, 32'h8000_0001);
    set_ch(31, 0, 127);
    check("R7 disable gates irq", irq, 32'h0000_0001);
    chk_stat("R7 status kept", 32'h8000_0001);
  endtask

  initial begin
    for (int k = 0; k < 8; k++) sel_sh[k] = '0;
    for (int k = 0; k < 2; k++) sns_sh[k] = '0;
    cyc(3);
    t_reset;
    rst_n = 1'b1;
    cyc(2);
    t_reset;
    t_regmap;
    t_rising;
    t_falling;
    t_level;
    t_disabled;
    t_switch;
    t_shared;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule